// File: doc/BRIEF.md
# Machine-Mode CSR and Trap Unit

This unit holds the machine-mode control and status registers of a 32-bit RISC-V core. It carries out the six CSR read-modify-write instructions and takes synchronous environment-call and breakpoint traps. The surrounding pipeline asserts a one-cycle strobe for each decoded SYSTEM instruction. With the strobe it presents funct3, the 12-bit CSR address (which doubles as funct12), the rs1 index, the rd index, the rs1 register value and the program counter of the instruction.

Each response comes out one clock after the strobe and is shown by a small state machine. The states are RESP_IDLE (nothing to report), RESP_WB (a one-cycle writeback pulse that carries the CSR value from before the instruction) and RESP_TRAP (a one-cycle trap pulse that carries the redirect target). The state machine enters RESP_WB on a CSR instruction whose rd is not x0. It enters RESP_TRAP on ECALL, EBREAK or the supervisor-return encoding. It enters RESP_IDLE on every other cycle. Because the next state depends only on the current strobe, back-to-back instructions are accepted. The CSR registers themselves update on the same edge that loads the response. The fetch stage must give trap_taken priority over its sequential PC update.

In vectored mode the trap target places exception entries 48 bytes past the interrupt entries. The supervisor-return encoding is deliberately handled as a breakpoint trap.

Top module: `mcsr_trap_unit`

## Requirements
- R1: After reset, mtvec (0x305), mepc (0x341), mcause (0x342) and mtval (0x343) read zero, and wb_en and trap_taken are low.
- R2: funct3 001 (swap) writes rs1_value into the addressed CSR. One cycle after the strobe, wb_en is high, wb_rd equals rd_idx, and wb_data holds the CSR value from before the instruction.
- R3: funct3 010 writes old OR rs1_value and funct3 011 writes old AND NOT rs1_value. Both return the old value.
- R4: funct3 101, 110 and 111 act like 001, 010 and 011 but use the rs1 index field, zero-extended to 32 bits, as the operand.
- R5: A CSR instruction with rd_idx = 0 raises no wb_en, but it still updates the CSR.
- R6: 0xF11, 0xF12, 0xF13 and 0xF14 read the VENDOR_ID, ARCH_ID, IMPL_ID and HART_ID parameters, and writes to them are ignored. Any address outside the thirteen implemented ones reads zero and ignores writes.
- R7: funct3 000 with funct12 0x000 raises trap_taken one cycle after the strobe. It also sets mcause to 11, mepc to the instruction's pc and mtval to 0.
- R8: funct3 000 with funct12 0x001, or with funct12 0x102, takes a trap the same way but sets mcause to 3.
- R9: When mtvec[1:0] is 00, trap_pc equals mtvec.
- R10: When mtvec[1:0] is not 00, trap_pc equals (mtvec with bits 1:0 cleared) + 48 + 4 × cause. This gives base+60 for cause 3 and base+92 for cause 11.
- R11: wb_en and trap_taken are single-cycle pulses that occur only after a strobe. Funct3 000 with any other funct12, and funct3 100, produce no pulse and change no CSR.
- R12: wb_en and trap_taken are never high together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| inst_valid | input | 1 | Strobe for a decoded SYSTEM instruction |
| funct3 | input | 3 | Instruction funct3 field |
| csr_field | input | 12 | CSR address, or funct12 when funct3 is 000 |
| rs1_idx | input | 5 | rs1 index, also the 5-bit immediate |
| rd_idx | input | 5 | Destination register index |
| rs1_value | input | 32 | Value of register rs1 |
| pc | input | 32 | Program counter of the instruction |
| wb_en | output | 1 | Writeback pulse |
| wb_rd | output | 5 | Writeback register index |
| wb_data | output | 32 | CSR value from before the instruction |
| trap_taken | output | 1 | Trap pulse; the redirect overrides sequential PC |
| trap_pc | output | 32 | Redirect target |

## Verification
The hardest case to reach is a vectored trap whose target depends on a cause that the trap itself writes. The target must be formed from the new cause code and the stored mtvec in the same cycle that mcause, mepc and mtval are overwritten. The bench gets there by first programming mtvec with a swap instruction and loading mtval with a non-zero value. It then issues ECALL, EBREAK and the supervisor-return encoding under direct mode and under two vectored bases. After each trap it reads mcause, mepc and mtval back with set instructions whose operand is zero, so the captured values are seen at the ports.

// File: rtl/mcsr_pkg.sv
package mcsr_pkg;

    localparam int XLEN   = 32;
    localparam int CSR_AW = 12;
    localparam int IDX_W  = 5;
    localparam int ID_CNT = 4;

    typedef enum logic [1:0] {
        ACT_NONE = 2'd0,
        ACT_CSR  = 2'd1,
        ACT_TRAP = 2'd2
    } act_e;

    typedef enum logic [1:0] {
        RMW_SWAP  = 2'd0,
        RMW_SET   = 2'd1,
        RMW_CLEAR = 2'd2
    } rmw_e;

    typedef enum logic [1:0] {
        RESP_IDLE = 2'd0,
        RESP_WB   = 2'd1,
        RESP_TRAP = 2'd2
    } resp_e;

    typedef struct packed {
        act_e              act;
        rmw_e              rmw;
        logic              use_imm;
        logic [XLEN-2:0]   cause;
    } cmd_t;

    localparam logic [CSR_AW-1:0] A_STATUS  = 12'h300;
    localparam logic [CSR_AW-1:0] A_ISA     = 12'h301;
    localparam logic [CSR_AW-1:0] A_IE      = 12'h304;
    localparam logic [CSR_AW-1:0] A_TVEC    = 12'h305;
    localparam logic [CSR_AW-1:0] A_SCRATCH = 12'h340;
    localparam logic [CSR_AW-1:0] A_EPC     = 12'h341;
    localparam logic [CSR_AW-1:0] A_CAUSE   = 12'h342;
    localparam logic [CSR_AW-1:0] A_TVAL    = 12'h343;
    localparam logic [CSR_AW-1:0] A_IP      = 12'h344;
    localparam logic [CSR_AW-1:0] A_ID_BASE = 12'hF11;

    localparam logic [CSR_AW-1:0] F12_ENV_CALL  = 12'h000;
    localparam logic [CSR_AW-1:0] F12_BREAK     = 12'h001;
    localparam logic [CSR_AW-1:0] F12_SUPER_RET = 12'h102;

    localparam logic [XLEN-2:0] CAUSE_ENV_CALL = 31'd11;
    localparam logic [XLEN-2:0] CAUSE_BREAK    = 31'd3;

endpackage

// File: rtl/mcsr_decode.sv
module mcsr_decode
    import mcsr_pkg::*;
(
    input  logic              valid,
    input  logic [2:0]        funct3,
    input  logic [CSR_AW-1:0] field,
    output cmd_t              cmd
);

    always_comb begin
        cmd.act     = ACT_NONE;
        cmd.rmw     = RMW_SWAP;
        cmd.use_imm = 1'b0;
        cmd.cause   = '0;
        if (valid) begin
            case (funct3)
                3'b000: begin
                    if (field == F12_ENV_CALL) begin
                        cmd.act   = ACT_TRAP;
                        cmd.cause = CAUSE_ENV_CALL;
                    end else if (field == F12_BREAK || field == F12_SUPER_RET) begin
                        cmd.act   = ACT_TRAP;
                        cmd.cause = CAUSE_BREAK;
                    end
                end
                3'b001: begin cmd.act = ACT_CSR; cmd.rmw = RMW_SWAP;  end
                3'b010: begin cmd.act = ACT_CSR; cmd.rmw = RMW_SET;   end
                3'b011: begin cmd.act = ACT_CSR; cmd.rmw = RMW_CLEAR; end
                3'b101: begin cmd.act = ACT_CSR; cmd.rmw = RMW_SWAP;  cmd.use_imm = 1'b1; end
                3'b110: begin cmd.act = ACT_CSR; cmd.rmw = RMW_SET;   cmd.use_imm = 1'b1; end
                3'b111: begin cmd.act = ACT_CSR; cmd.rmw = RMW_CLEAR; cmd.use_imm = 1'b1; end
                default: cmd.act = ACT_NONE;
            endcase
        end
    end

endmodule

// File: rtl/mcsr_trap_vector.sv
module mcsr_trap_vector
    import mcsr_pkg::*;
#(
    parameter int EXC_VEC_OFFSET = 48
) (
    input  logic [XLEN-1:0] tvec,
    input  logic            is_irq,
    input  logic [XLEN-2:0] cause_code,
    output logic [XLEN-1:0] target
);

    localparam logic [XLEN-1:0] EXC_OFF = XLEN'(EXC_VEC_OFFSET);

    logic [XLEN-1:0] base;
    logic [XLEN-1:0] bank_off;
    logic [XLEN-1:0] slot_off;

    always_comb begin
        base     = {tvec[XLEN-1:2], 2'b00};
        bank_off = is_irq ? '0 : EXC_OFF;
        slot_off = {cause_code[XLEN-4:0], 2'b00};
        if (tvec[1:0] == 2'b00)
            target = tvec;
        else
            target = base + bank_off + slot_off;
    end

endmodule

// File: rtl/mcsr_regs.sv
module mcsr_regs
    import mcsr_pkg::*;
#(
    parameter logic [XLEN-1:0] VENDOR_ID  = 32'h0,
    parameter logic [XLEN-1:0] ARCH_ID    = 32'h0,
    parameter logic [XLEN-1:0] IMPL_ID    = 32'h0,
    parameter logic [XLEN-1:0] HART_ID    = 32'h0,
    parameter logic [XLEN-1:0] MISA_RESET = 32'h4000_0100
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CSR_AW-1:0] addr,
    output logic [XLEN-1:0]   rd_data,
    input  logic              wr_en,
    input  rmw_e              wr_op,
    input  logic [XLEN-1:0]   wr_operand,
    input  logic              trap_we,
    input  logic [XLEN-1:0]   trap_epc,
    input  logic [XLEN-2:0]   trap_cause,
    output logic [XLEN-1:0]   tvec_o
);

    logic [XLEN-1:0] status_q, isa_q, ie_q, tvec_q, scratch_q;
    logic [XLEN-1:0] epc_q, cause_q, tval_q, ip_q;

    logic [XLEN-1:0] rw_data;
    logic            rw_hit;
    logic [XLEN-1:0] new_val;
    logic [ID_CNT-1:0] id_hit;
    logic [XLEN-1:0]   id_term [ID_CNT];
    logic [XLEN-1:0]   id_data;

    function automatic logic [XLEN-1:0] id_value(input int idx);
        case (idx)
            0:       return VENDOR_ID;
            1:       return ARCH_ID;
            2:       return IMPL_ID;
            default: return HART_ID;
        endcase
    endfunction

    for (genvar g = 0; g < ID_CNT; g++) begin : g_id
        assign id_hit[g]  = (addr == A_ID_BASE + CSR_AW'(g));
        assign id_term[g] = id_hit[g] ? id_value(g) : '0;
    end

    always_comb begin
        id_data = '0;
        for (int k = 0; k < ID_CNT; k++) id_data = id_data | id_term[k];
    end

    always_comb begin
        rw_hit  = 1'b1;
        rw_data = '0;
        case (addr)
            A_STATUS:  rw_data = status_q;
            A_ISA:     rw_data = isa_q;
            A_IE:      rw_data = ie_q;
            A_TVEC:    rw_data = tvec_q;
            A_SCRATCH: rw_data = scratch_q;
            A_EPC:     rw_data = epc_q;
            A_CAUSE:   rw_data = cause_q;
            A_TVAL:    rw_data = tval_q;
            A_IP:      rw_data = ip_q;
            default:   rw_hit  = 1'b0;
        endcase
        rd_data = rw_data | id_data;
    end

    always_comb begin
        unique case (wr_op)
            RMW_SET:   new_val = rw_data | wr_operand;
            RMW_CLEAR: new_val = rw_data & ~wr_operand;
            default:   new_val = wr_operand;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            status_q  <= '0;
            isa_q     <= MISA_RESET;
            ie_q      <= '0;
            tvec_q    <= '0;
            scratch_q <= '0;
            epc_q     <= '0;
            cause_q   <= '0;
            tval_q    <= '0;
            ip_q      <= '0;
        end else if (trap_we) begin
            epc_q   <= trap_epc;
            cause_q <= {1'b0, trap_cause};
            tval_q  <= '0;
        end else if (wr_en && rw_hit) begin
            case (addr)
                A_STATUS:  status_q  <= new_val;
                A_ISA:     isa_q     <= new_val;
                A_IE:      ie_q      <= new_val;
                A_TVEC:    tvec_q    <= new_val;
                A_SCRATCH: scratch_q <= new_val;
                A_EPC:     epc_q     <= new_val;
                A_CAUSE:   cause_q   <= new_val;
                A_TVAL:    tval_q    <= new_val;
                A_IP:      ip_q      <= new_val;
                default:   ;
            endcase
        end
    end

    assign tvec_o = tvec_q;

    // R7
    epc_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trap_we |=> (epc_q == $past(trap_epc)) && (tval_q == '0));

    // R6
    ro_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !trap_we && !rw_hit) |=> $stable(scratch_q) && $stable(tvec_q)
            && $stable(cause_q) && $stable(epc_q) && $stable(status_q));

endmodule

// File: rtl/mcsr_trap_unit.sv
module mcsr_trap_unit
    import mcsr_pkg::*;
#(
    parameter logic [31:0] VENDOR_ID      = 32'h0,
    parameter logic [31:0] ARCH_ID        = 32'h0,
    parameter logic [31:0] IMPL_ID        = 32'h0,
    parameter logic [31:0] HART_ID        = 32'h0,
    parameter logic [31:0] MISA_RESET     = 32'h4000_0100,
    parameter int          EXC_VEC_OFFSET = 48
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        inst_valid,
    input  logic [2:0]  funct3,
    input  logic [11:0] csr_field,
    input  logic [4:0]  rs1_idx,
    input  logic [4:0]  rd_idx,
    input  logic [31:0] rs1_value,
    input  logic [31:0] pc,
    output logic        wb_en,
    output logic [4:0]  wb_rd,
    output logic [31:0] wb_data,
    output logic        trap_taken,
    output logic [31:0] trap_pc
);

    cmd_t            cmd;
    logic [XLEN-1:0] operand;
    logic [XLEN-1:0] csr_old;
    logic [XLEN-1:0] tvec;
    logic [XLEN-1:0] vec_target;
    logic            csr_we;
    logic            trap_we;

    resp_e           state_q, state_d;
    logic [XLEN-1:0] wb_data_q;
    logic [IDX_W-1:0] wb_rd_q;
    logic [XLEN-1:0] trap_pc_q;

    mcsr_decode u_decode (
        .valid  (inst_valid),
        .funct3 (funct3),
        .field  (csr_field),
        .cmd    (cmd)
    );

    assign operand = cmd.use_imm ? {{(XLEN-IDX_W){1'b0}}, rs1_idx} : rs1_value;
    assign csr_we  = (cmd.act == ACT_CSR);
    assign trap_we = (cmd.act == ACT_TRAP);

    mcsr_regs #(
        .VENDOR_ID  (VENDOR_ID),
        .ARCH_ID    (ARCH_ID),
        .IMPL_ID    (IMPL_ID),
        .HART_ID    (HART_ID),
        .MISA_RESET (MISA_RESET)
    ) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .addr       (csr_field),
        .rd_data    (csr_old),
        .wr_en      (csr_we),
        .wr_op      (cmd.rmw),
        .wr_operand (operand),
        .trap_we    (trap_we),
        .trap_epc   (pc),
        .trap_cause (cmd.cause),
        .tvec_o     (tvec)
    );

    mcsr_trap_vector #(
        .EXC_VEC_OFFSET (EXC_VEC_OFFSET)
    ) u_vector (
        .tvec       (tvec),
        .is_irq     (1'b0),
        .cause_code (cmd.cause),
        .target     (vec_target)
    );

    // Next-state logic: the response depends on the strobe of this cycle.
    always_comb begin
        unique case (cmd.act)
            ACT_CSR:  state_d = (rd_idx != '0) ? RESP_WB : RESP_IDLE;
            ACT_TRAP: state_d = RESP_TRAP;
            default:  state_d = RESP_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= RESP_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wb_data_q <= '0;
            wb_rd_q   <= '0;
            trap_pc_q <= '0;
        end else begin
            if (csr_we) begin
                wb_data_q <= csr_old;
                wb_rd_q   <= rd_idx;
            end
            if (trap_we) trap_pc_q <= vec_target;
        end
    end

    // Output process
    always_comb begin
        wb_en      = 1'b0;
        trap_taken = 1'b0;
        unique case (state_q)
            RESP_WB:   wb_en      = 1'b1;
            RESP_TRAP: trap_taken = 1'b1;
            default:   ;
        endcase
        wb_rd   = wb_rd_q;
        wb_data = wb_data_q;
        trap_pc = trap_pc_q;
    end

    // R12
    pulse_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(wb_en && trap_taken));

    // R11
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !inst_valid |=> (!wb_en && !trap_taken));

    // R5
    rd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wb_en |-> (wb_rd != '0));

    // R9
    direct_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (trap_taken && tvec[1:0] == 2'b00) |-> (trap_pc == tvec));

    // R10
    vector_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (trap_taken && tvec[1:0] != 2'b00) |-> (trap_pc[1:0] == 2'b00));

endmodule

// File: tb/test_mcsr_trap_unit.sv
module test_mcsr_trap_unit;

    localparam int CLK_PERIOD = 10;
    localparam logic [31:0] P_VENDOR = 32'h0000_0A11;
    localparam logic [31:0] P_ARCH   = 32'h0000_0022;
    localparam logic [31:0] P_IMPL   = 32'h0000_0303;
    localparam logic [31:0] P_HART   = 32'h0000_0004;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        inst_valid = 1'b0;
    logic [2:0]  funct3 = '0;
    logic [11:0] csr_field = '0;
    logic [4:0]  rs1_idx = '0;
    logic [4:0]  rd_idx = '0;
    logic [31:0] rs1_value = '0;
    logic [31:0] pc = '0;
    logic        wb_en;
    logic [4:0]  wb_rd;
    logic [31:0] wb_data;
    logic        trap_taken;
    logic [31:0] trap_pc;

    int total = 0;
    int bad = 0;
    bit done = 0;

    logic        s_wb_en, s_trap;
    logic [4:0]  s_wb_rd;
    logic [31:0] s_wb_data, s_tpc;

    always #(CLK_PERIOD/2) clk = ~clk;

    mcsr_trap_unit #(
        .VENDOR_ID (P_VENDOR),
        .ARCH_ID   (P_ARCH),
        .IMPL_ID   (P_IMPL),
        .HART_ID   (P_HART)
    ) i_mcsr_trap_unit (
        .clk        (clk),
        .rst_n      (rst_n),
        .inst_valid (inst_valid),
        .funct3     (funct3),
        .csr_field  (csr_field),
        .rs1_idx    (rs1_idx),
        .rd_idx     (rd_idx),
        .rs1_value  (rs1_value),
        .pc         (pc),
        .wb_en      (wb_en),
        .wb_rd      (wb_rd),
        .wb_data    (wb_data),
        .trap_taken (trap_taken),
        .trap_pc    (trap_pc)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%08h expected=%08h", req, what, act, exp);
        end
    endtask

    task automatic sample();
        s_wb_en   = wb_en;
        s_trap    = trap_taken;
        s_wb_rd   = wb_rd;
        s_wb_data = wb_data;
        s_tpc     = trap_pc;
    endtask

    // Drive one strobe, sample the registered response one clock later.
    task automatic do_op(input logic [2:0] f3, input logic [11:0] fld,
                         input logic [4:0] r1, input logic [4:0] rd,
                         input logic [31:0] val, input logic [31:0] p);
        @(negedge clk);
        funct3 = f3; csr_field = fld; rs1_idx = r1; rd_idx = rd;
        rs1_value = val; pc = p; inst_valid = 1'b1;
        @(negedge clk);
        inst_valid = 1'b0;
        sample();
        chk("R12", "wb/trap overlap", {31'd0, s_wb_en & s_trap}, 32'd0);
    endtask

    task automatic read_csr(input logic [11:0] a, output logic [31:0] v);
        do_op(3'b010, a, 5'd0, 5'd1, 32'd0, 32'd0);
        v = s_wb_data;
    endtask

    task automatic write_csr(input logic [11:0] a, input logic [31:0] v);
        do_op(3'b001, a, 5'd2, 5'd0, v, 32'd0);
    endtask

    task automatic t_reset();
        logic [31:0] v;
        sample();
        chk("R1", "wb_en after reset", {31'd0, s_wb_en}, 32'd0);
        chk("R1", "trap after reset", {31'd0, s_trap}, 32'd0);
        read_csr(12'h305, v); chk("R1", "mtvec", v, 32'd0);
        read_csr(12'h341, v); chk("R1", "mepc", v, 32'd0);
        read_csr(12'h342, v); chk("R1", "mcause", v, 32'd0);
        read_csr(12'h343, v); chk("R1", "mtval", v, 32'd0);
    endtask

    task automatic t_swap();
        logic [31:0] v;
        do_op(3'b001, 12'h340, 5'd7, 5'd9, 32'hA5A5_0001, 32'd0);
        chk("R2", "swap wb_en", {31'd0, s_wb_en}, 32'd1);
        chk("R2", "swap wb_rd", {27'd0, s_wb_rd}, 32'd9);
        chk("R2", "swap old value", s_wb_data, 32'd0);
        do_op(3'b001, 12'h340, 5'd7, 5'd3, 32'h1234_5678, 32'd0);
        chk("R2", "swap returns previous", s_wb_data, 32'hA5A5_0001);
        read_csr(12'h340, v); chk("R2", "swap stored", v, 32'h1234_5678);
    endtask

    task automatic t_set_clear();
        logic [31:0] v;
        write_csr(12'h304, 32'h0000_00F0);
        do_op(3'b010, 12'h304, 5'd4, 5'd5, 32'hF000_000F, 32'd0);
        chk("R3", "set old", s_wb_data, 32'h0000_00F0);
        read_csr(12'h304, v); chk("R3", "set result", v, 32'hF000_00FF);
        do_op(3'b011, 12'h304, 5'd4, 5'd5, 32'h1000_0033, 32'd0);
        chk("R3", "clear old", s_wb_data, 32'hF000_00FF);
        read_csr(12'h304, v); chk("R3", "clear result", v, 32'hE000_00CC);
    endtask

    task automatic t_imm();
        logic [31:0] v;
        do_op(3'b101, 12'h340, 5'h1F, 5'd6, 32'hFFFF_FFFF, 32'd0);
        read_csr(12'h340, v); chk("R4", "swap imm", v, 32'h0000_001F);
        do_op(3'b111, 12'h340, 5'h05, 5'd6, 32'hFFFF_FFFF, 32'd0);
        chk("R4", "clear imm old", s_wb_data, 32'h0000_001F);
        read_csr(12'h340, v); chk("R4", "clear imm", v, 32'h0000_001A);
        do_op(3'b110, 12'h340, 5'h10, 5'd6, 32'h0000_0000, 32'd0);
        read_csr(12'h340, v); chk("R4", "set imm", v, 32'h0000_001A);
        do_op(3'b110, 12'h340, 5'h01, 5'd6, 32'h0000_0000, 32'd0);
        read_csr(12'h340, v); chk("R4", "set imm bit0", v, 32'h0000_001B);
    endtask

    task automatic t_rd_zero();
        logic [31:0] v;
        do_op(3'b001, 12'h340, 5'd2, 5'd0, 32'hCAFE_F00D, 32'd0);
        chk("R5", "no wb for x0", {31'd0, s_wb_en}, 32'd0);
        read_csr(12'h340, v); chk("R5", "write still done", v, 32'hCAFE_F00D);
    endtask

    task automatic t_ids();
        logic [31:0] v;
        read_csr(12'hF11, v); chk("R6", "vendor id", v, P_VENDOR);
        read_csr(12'hF12, v); chk("R6", "arch id", v, P_ARCH);
        read_csr(12'hF13, v); chk("R6", "impl id", v, P_IMPL);
        write_csr(12'hF14, 32'hFFFF_0000);
        read_csr(12'hF14, v); chk("R6", "hart id after write", v, P_HART);
        write_csr(12'h7C0, 32'h5555_AAAA);
        read_csr(12'h7C0, v); chk("R6", "unimplemented reads 0", v, 32'd0);
        read_csr(12'h340, v); chk("R6", "scratch untouched", v, 32'hCAFE_F00D);
    endtask

    task automatic t_direct_trap();
        logic [31:0] v;
        write_csr(12'h305, 32'h0000_1000);
        write_csr(12'h343, 32'hDEAD_BEEF);
        do_op(3'b000, 12'h000, 5'd0, 5'd0, 32'd0, 32'h0000_0484);
        chk("R7", "ecall trap", {31'd0, s_trap}, 32'd1);
        chk("R9", "direct target", s_tpc, 32'h0000_1000);
        @(negedge clk); sample();
        chk("R11", "trap is one cycle", {31'd0, s_trap}, 32'd0);
        read_csr(12'h342, v); chk("R7", "mcause ecall", v, 32'd11);
        read_csr(12'h341, v); chk("R7", "mepc", v, 32'h0000_0484);
        read_csr(12'h343, v); chk("R7", "mtval cleared", v, 32'd0);
        do_op(3'b000, 12'h001, 5'd0, 5'd0, 32'd0, 32'h0000_0600);
        chk("R9", "direct target ebreak", s_tpc, 32'h0000_1000);
        read_csr(12'h342, v); chk("R8", "mcause ebreak", v, 32'd3);
    endtask

    task automatic t_vector_trap();
        logic [31:0] v;
        write_csr(12'h305, 32'h0000_2001);
        do_op(3'b000, 12'h001, 5'd0, 5'd0, 32'd0, 32'h0000_0700);
        chk("R8", "ebreak trap", {31'd0, s_trap}, 32'd1);
        chk("R10", "vectored ebreak", s_tpc, 32'h0000_203C);
        do_op(3'b000, 12'h102, 5'd0, 5'd0, 32'd0, 32'h0000_0710);
        chk("R8", "super-ret trap", {31'd0, s_trap}, 32'd1);
        chk("R10", "vectored super-ret", s_tpc, 32'h0000_203C);
        read_csr(12'h342, v); chk("R8", "mcause super-ret", v, 32'd3);
        read_csr(12'h341, v); chk("R8", "mepc super-ret", v, 32'h0000_0710);
        do_op(3'b000, 12'h000, 5'd0, 5'd0, 32'd0, 32'h0000_0720);
        chk("R10", "vectored ecall", s_tpc, 32'h0000_205C);
        write_csr(12'h305, 32'h0000_3003);
        do_op(3'b000, 12'h000, 5'd0, 5'd0, 32'd0, 32'h0000_0730);
        chk("R10", "vectored ecall mode 3", s_tpc, 32'h0000_305C);
    endtask

    task automatic t_ignored();
        logic [31:0] v;
        do_op(3'b000, 12'h105, 5'd0, 5'd4, 32'd0, 32'h0000_0800);
        chk("R11", "other funct12 no trap", {31'd0, s_trap}, 32'd0);
        chk("R11", "other funct12 no wb", {31'd0, s_wb_en}, 32'd0);
        do_op(3'b100, 12'h340, 5'd3, 5'd4, 32'h1111_1111, 32'd0);
        chk("R11", "funct3 100 no wb", {31'd0, s_wb_en}, 32'd0);
        read_csr(12'h340, v); chk("R11", "funct3 100 no write", v, 32'hCAFE_F00D);
        read_csr(12'h341, v); chk("R11", "mepc unchanged", v, 32'h0000_0730);
        @(negedge clk);
        funct3 = 3'b000; csr_field = 12'h000; inst_valid = 1'b0;
        @(negedge clk); sample();
        chk("R11", "no strobe no trap", {31'd0, s_trap}, 32'd0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_swap();
        t_set_clear();
        t_imm();
        t_rd_zero();
        t_ids();
        t_direct_trap();
        t_vector_trap();
        t_ignored();
        if (!done) begin
            done = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            total++;
            bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule